// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block derives a periodic frame sync for a time-division-multiplexed serial bus from the bus bit clock, which also clocks the block. Each frame is a high phase followed by a low phase. Software programs the length of each phase, in bit-clock cycles, as an 11-bit value. A control word turns the sync output on and chooses whether the sync changes just after the rising edge of the bit clock or half a cycle later, on the falling edge.

The phase counter works from shadow copies of the two widths. Those copies are refreshed only while the generator is disabled or at the moment a new frame begins, so a width written in the middle of a frame never cuts a phase short or stretches it. While the output is disabled the generator is held at the first cycle of the high phase. Setting enable therefore always starts a clean frame. With the usual values of a high width of 1 and a low width of 255 on a 2.048 MHz bit clock, the frame is 256 cycles long, which is 8 kHz.

Register writes take one cycle through a simple write port. Reads come back combinationally on a separate read port.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset the control word reads 0, the high width reads 1, the low width reads 0xFF, and `fs_out` is 0.
- R2: The control word is at byte offset 0x08, with bit 0 as output enable and bit 1 as falling-edge select. The low width is at 0x0C and the high width at 0x10, each in bits [10:0]. A write of 0..0x7FF is stored and read back the cycle after the write edge. Reading any other offset returns 0.
- R3: A write of a value above 0x7FF to either width register is rejected, and the register keeps its previous value.
- R4: While enable is 0, `fs_out` is 0 and the generator is held at the first cycle of the high phase, with its shadow widths following the registers.
- R5: While enabled, the sync is 1 for the high width and then 0 for the low width, in bit-clock cycles, so the frame period is their sum. A width of 0 counts as 1 cycle.
- R6: Width values written during a frame take effect only at the start of the next frame.
- R7: With falling-edge select 0, `fs_out` changes just after the rising clock edge. With it set to 1, the same sequence appears delayed to the following falling edge.
- R8: When enable is written to 1, the high phase of the first frame begins at that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the generator runs on both of its edges |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 5 | Read byte offset |
| reg_rdata | output | 32 | Read data, combinational |
| fs_out | output | 1 | Frame sync output |

## Verification
Assertions check a set of properties on every cycle. Out-of-range width writes must leave the register unchanged. A disabled generator must keep the output low and sit at the start of the high phase. The phase counter must stay inside the current phase width. The shadow widths must stay constant except at a frame boundary. Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural model at two points in every cycle: the exact phase lengths, the half-cycle lag in falling-edge mode, the moment a mid-frame width change takes effect, and the treatment of zero widths.

// File: rtl/fsg_pkg.sv
// Shared constants and types for the frame sync generator.
// Assumes byte offsets on a small register window and 11-bit phase widths.
package fsg_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int WID_W  = 11;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_LOW  = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_HIGH = 5'h10;

    localparam logic [WID_W-1:0] RST_LOW  = 11'd255;
    localparam logic [WID_W-1:0] RST_HIGH = 11'd1;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_t;
endpackage

// File: rtl/fsg_regs.sv
// Register file: control word (enable, falling-edge select) and two phase widths.
// A width write with any bit set above the width field is dropped.
// Assumes single-cycle writes and combinational reads.
module fsg_regs #(
    parameter int ADDR_W = fsg_pkg::ADDR_W,
    parameter int DATA_W = fsg_pkg::DATA_W,
    parameter int WID_W  = fsg_pkg::WID_W,
    parameter logic [ADDR_W-1:0] A_CTRL = fsg_pkg::ADR_CTRL,
    parameter logic [ADDR_W-1:0] A_LOW  = fsg_pkg::ADR_LOW,
    parameter logic [ADDR_W-1:0] A_HIGH = fsg_pkg::ADR_HIGH,
    parameter logic [WID_W-1:0]  LOW_INIT  = fsg_pkg::RST_LOW,
    parameter logic [WID_W-1:0]  HIGH_INIT = fsg_pkg::RST_HIGH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic              fall,
    output logic [WID_W-1:0]  lo_w,
    output logic [WID_W-1:0]  hi_w
);
    localparam logic [DATA_W-1:0] MAXV = DATA_W'((64'd1 << WID_W) - 64'd1);

    logic in_range;

    // Range test shared by both width registers.
    always_comb in_range = (wdata <= MAXV);

    // Register update on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            fall <= 1'b0;
            lo_w <= LOW_INIT;
            hi_w <= HIGH_INIT;
        end else if (wr) begin
            case (waddr)
                A_CTRL: begin
                    en   <= wdata[0];
                    fall <= wdata[1];
                end
                A_LOW:  if (in_range) lo_w <= wdata[WID_W-1:0];
                A_HIGH: if (in_range) hi_w <= wdata[WID_W-1:0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer; unmapped offsets read as zero.
    always_comb begin
        rdata = '0;
        case (raddr)
            A_CTRL: rdata[1:0]       = {fall, en};
            A_LOW:  rdata[WID_W-1:0] = lo_w;
            A_HIGH: rdata[WID_W-1:0] = hi_w;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fsg_phase_ctr.sv
// Phase sequencer: counts bit-clock cycles through the high and low phases.
// It works from shadow widths that load while disabled or at a frame start.
// A width of zero is stretched to one cycle. Assumes widths come from fsg_regs.
module fsg_phase_ctr #(
    parameter int WID_W = fsg_pkg::WID_W,
    parameter logic [WID_W-1:0] LOW_INIT  = fsg_pkg::RST_LOW,
    parameter logic [WID_W-1:0] HIGH_INIT = fsg_pkg::RST_HIGH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WID_W-1:0] lo_w,
    input  logic [WID_W-1:0] hi_w,
    output logic             ph_high,
    output logic [WID_W-1:0] cnt,
    output logic [WID_W-1:0] shadow_lo,
    output logic [WID_W-1:0] shadow_hi,
    output logic             wrap
);
    import fsg_pkg::*;

    phase_t           ph;
    logic [WID_W-1:0] cur_len;
    logic             last;

    // Length of the phase in progress, zero stretched to one.
    always_comb begin
        if (ph == PH_HIGH) cur_len = (shadow_hi == '0) ? WID_W'(1) : shadow_hi;
        else               cur_len = (shadow_lo == '0) ? WID_W'(1) : shadow_lo;
    end

    // Final cycle of a phase, and the frame boundary at the end of the low phase.
    always_comb begin
        last    = (cnt == cur_len - WID_W'(1));
        wrap    = en && (ph == PH_LOW) && last;
        ph_high = (ph == PH_HIGH);
    end

    // Phase and counter advance; shadow widths reload while idle or at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_HIGH;
            cnt       <= '0;
            shadow_lo <= LOW_INIT;
            shadow_hi <= HIGH_INIT;
        end else if (!en) begin
            ph        <= PH_HIGH;
            cnt       <= '0;
            shadow_lo <= lo_w;
            shadow_hi <= hi_w;
        end else if (last) begin
            cnt <= '0;
            if (ph == PH_HIGH) begin
                ph <= PH_LOW;
            end else begin
                ph        <= PH_HIGH;
                shadow_lo <= lo_w;
                shadow_hi <= hi_w;
            end
        end else begin
            cnt <= cnt + WID_W'(1);
        end
    end
endmodule

// File: rtl/fsg_edge_out.sv
// Output stage: chooses rising- or falling-edge timing and gates with enable.
// The falling-edge path retimes the rising-edge phase on the negative clock edge.
// Assumes ph_high comes from a rising-edge register.
module fsg_edge_out (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_high,
    input  logic en,
    input  logic fall,
    output logic fs_out
);
    logic fall_q;

    // Half-cycle retiming of the phase for falling-edge mode.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= ph_high;
    end

    // Edge select and output gating.
    always_comb fs_out = en & (fall ? fall_q : ph_high);
endmodule

// File: rtl/frame_sync_gen.sv
// Top level of the programmable frame sync generator.
// It connects the register file, the phase sequencer and the output stage.
// clk is the bus bit clock. Reset is synchronous and active low.
module frame_sync_gen #(
    parameter int ADDR_W = fsg_pkg::ADDR_W,
    parameter int DATA_W = fsg_pkg::DATA_W,
    parameter int WID_W  = fsg_pkg::WID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fs_out
);
    logic             ctrl_en;
    logic             ctrl_fall;
    logic [WID_W-1:0] lo_w;
    logic [WID_W-1:0] hi_w;
    logic             ph_high;
    logic [WID_W-1:0] ph_cnt;
    logic [WID_W-1:0] shadow_lo;
    logic [WID_W-1:0] shadow_hi;
    logic             frame_wrap;

    fsg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WID_W(WID_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata),
        .en    (ctrl_en),
        .fall  (ctrl_fall),
        .lo_w  (lo_w),
        .hi_w  (hi_w)
    );

    fsg_phase_ctr #(.WID_W(WID_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_en),
        .lo_w      (lo_w),
        .hi_w      (hi_w),
        .ph_high   (ph_high),
        .cnt       (ph_cnt),
        .shadow_lo (shadow_lo),
        .shadow_hi (shadow_hi),
        .wrap      (frame_wrap)
    );

    fsg_edge_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph_high (ph_high),
        .en      (ctrl_en),
        .fall    (ctrl_fall),
        .fs_out  (fs_out)
    );
endmodule

// File: rtl/frame_sync_gen_chk.sv
// Checker for frame_sync_gen, attached by bind. It watches register rejection,
// the idle hold, the counter bound and the shadow-width stability.
module frame_sync_gen_chk #(
    parameter int ADDR_W = fsg_pkg::ADDR_W,
    parameter int DATA_W = fsg_pkg::DATA_W,
    parameter int WID_W  = fsg_pkg::WID_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_waddr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              fs_out,
    input logic              en,
    input logic [WID_W-1:0]  lo_w,
    input logic [WID_W-1:0]  hi_w,
    input logic              ph_high,
    input logic [WID_W-1:0]  cnt,
    input logic [WID_W-1:0]  slo,
    input logic [WID_W-1:0]  shi,
    input logic              wrap
);
    localparam logic [DATA_W-1:0] MAXV = DATA_W'((64'd1 << WID_W) - 64'd1);

    logic [WID_W-1:0] len_now;
    always_comb begin
        if (ph_high) len_now = (shi == '0) ? WID_W'(1) : shi;
        else         len_now = (slo == '0) ? WID_W'(1) : slo;
    end

    // R3
    low_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_waddr == fsg_pkg::ADR_LOW && reg_wdata > MAXV) |=> $stable(lo_w));

    // R3
    high_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_waddr == fsg_pkg::ADR_HIGH && reg_wdata > MAXV) |=> $stable(hi_w));

    // R4
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !fs_out);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ph_high && cnt == '0));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < len_now));

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> ($stable(slo) && $stable(shi)));
endmodule

bind frame_sync_gen frame_sync_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .fs_out    (fs_out),
    .en        (ctrl_en),
    .lo_w      (lo_w),
    .hi_w      (hi_w),
    .ph_high   (ph_high),
    .cnt       (ph_cnt),
    .slo       (shadow_lo),
    .shi       (shadow_hi),
    .wrap      (frame_wrap)
);

// File: tb/sim_frame_sync_gen.sv
module sim_frame_sync_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [4:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        fs_out;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_en = 0, m_fall = 0, m_lo = 255, m_hi = 1;
    int m_slo = 255, m_shi = 1, m_high = 1, m_cnt = 0, m_fq = 0;

    frame_sync_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .fs_out(fs_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic int eff(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    // reference model, rising edge: generator first on old values, then writes
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_fall = 0; m_lo = 255; m_hi = 1;
            m_slo = 255; m_shi = 1; m_high = 1; m_cnt = 0;
        end else begin
            if (m_en == 0) begin
                m_high = 1; m_cnt = 0; m_slo = m_lo; m_shi = m_hi;
            end else begin
                int w;
                w = m_high ? eff(m_shi) : eff(m_slo);
                if (m_cnt >= w - 1) begin
                    m_cnt = 0;
                    if (m_high == 1) m_high = 0;
                    else begin m_high = 1; m_slo = m_lo; m_shi = m_hi; end
                end else m_cnt++;
            end
            if (reg_wr) begin
                if (reg_waddr == 5'h08) begin m_en = int'(reg_wdata[0]); m_fall = int'(reg_wdata[1]); end
                if (reg_waddr == 5'h0C && reg_wdata <= 32'h7FF) m_lo = int'(reg_wdata);
                if (reg_waddr == 5'h10 && reg_wdata <= 32'h7FF) m_hi = int'(reg_wdata);
            end
        end
    end

    // reference model, falling edge retiming
    always @(negedge clk) m_fq = rst_n ? m_high : 0;

    // compare the sync output a quarter cycle after each edge
    always @(posedge clk) begin
        #2;
        chk(cur_req, {31'd0, fs_out}, (m_en != 0 && ((m_fall != 0) ? m_fq : m_high) != 0) ? 32'd1 : 32'd0);
        #4;
        chk(cur_req, {31'd0, fs_out}, (m_en != 0 && ((m_fall != 0) ? m_fq : m_high) != 0) ? 32'd1 : 32'd0);
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        reg_raddr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
    endtask

    initial begin
        run(3);
        rst_n = 1'b1;
        // R1 reset values
        rd("R1", 5'h08, 32'h0);
        rd("R1", 5'h0C, 32'hFF);
        rd("R1", 5'h10, 32'h1);
        chk("R1", {31'd0, fs_out}, 32'd0);

        // R2 storage and decoding
        cur_req = "R2";
        wr(5'h10, 32'd3);
        wr(5'h0C, 32'd5);
        rd("R2", 5'h10, 32'd3);
        rd("R2", 5'h0C, 32'd5);
        rd("R2", 5'h04, 32'd0);
        wr(5'h0C, 32'h7FF);
        rd("R2", 5'h0C, 32'h7FF);
        wr(5'h0C, 32'd5);

        // R3 out-of-range writes rejected
        cur_req = "R3";
        wr(5'h0C, 32'h800);
        rd("R3", 5'h0C, 32'd5);
        wr(5'h10, 32'hFFFF_FFFF);
        rd("R3", 5'h10, 32'd3);

        // R8 enable starts a frame in the high phase at the write edge
        cur_req = "R8";
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_waddr = 5'h08; reg_wdata = 32'h1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        chk("R8", {31'd0, fs_out}, 32'd1);
        rd("R2", 5'h08, 32'h1);

        // R5 rising-edge frames, high 3 low 5
        cur_req = "R5";
        run(40);

        // R7 falling-edge timing
        cur_req = "R7";
        wr(5'h08, 32'h3);
        rd("R7", 5'h08, 32'h3);
        run(40);

        // R6 mid-frame width change
        cur_req = "R6";
        run(2);
        wr(5'h10, 32'd2);
        wr(5'h0C, 32'd1);
        run(30);
        wr(5'h08, 32'h1);
        wr(5'h10, 32'd7);
        run(30);

        // R5 zero widths count as one cycle
        cur_req = "R5";
        wr(5'h10, 32'd0);
        wr(5'h0C, 32'd0);
        run(20);

        // R4 disable mid-frame, change widths while idle, re-enable
        cur_req = "R4";
        run(1);
        wr(5'h08, 32'h2);
        run(10);
        chk("R4", {31'd0, fs_out}, 32'd0);
        wr(5'h10, 32'd4);
        wr(5'h0C, 32'd2);
        cur_req = "R8";
        wr(5'h08, 32'h3);
        run(30);

        // R5 typical 256-cycle frame from reset values
        do_reset();
        cur_req = "R5";
        wr(5'h08, 32'h1);
        run(600);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule